// File: doc/BRIEF.md
# SDA Hold-Delay and Input Filter Stage

This stage sits between the byte shifter of a two-wire serial controller and the SDA pad. When the shifter asks for a new SDA drive level, the stage holds that change back until SCL has fallen. It then waits a programmable number of clock cycles before the pad output-enable follows. This stretches the data hold time after the clock edge. The delay is chosen as a multiple of five cycles, from zero to fifteen. A code of zero turns the stage into a one-register pass-through.

In the receive direction, the raw SDA pin is brought into the clock domain through two flops. An optional glitch filter can then be switched on. While the filter is active, the filtered level only moves once the synchronised pin has shown the same value for three clock samples in a row.

Both settings live in a single 3-bit line-control register at byte offset 0x10 on a simple write port. Drive requests use the open-drain sense: a 1 on the request or on the output-enable pulls SDA low.

Top module: `sda_line_cond`

## Requirements
- R1: A write with `cfg_addr` equal to 0x10 loads `cfg_wdata[1:0]` as the delay code and `cfg_wdata[2]` as the filter enable. Bits above 2 are ignored, and writes to any other address leave the configuration unchanged.
- R2: With delay code 0, `sda_oe` equals the value `drv_req` had at the previous clock edge, whatever SCL is doing.
- R3: With a nonzero delay code n, `sda_oe` takes the value of `drv_req` at the 5·n-th clock edge after the edge that first samples SCL low following a high sample. Before that edge it does not change.
- R4: Delay code 3 gives the largest delay, 15 clock edges after the SCL fall is sampled.
- R5: With a nonzero code, a change of `drv_req` made while SCL stays high does not reach `sda_oe` until the next SCL fall plus the programmed delay.
- R6: An SCL fall sampled while a delay is still counting restarts the count from that fall.
- R7: With the filter disabled (bit 2 = 0), `sda_in_filt` equals the value `sda_pin` had two clock edges earlier.
- R8: With the filter enabled, `sda_in_filt` changes only after three consecutive equal samples of the synchronised pin, and it moves four edges after the first sample of the new level. A pin pulse lasting two clocks or less is suppressed, and a pulse of three clocks passes.
- R9: After reset, `sda_oe` is 0 (line released), `sda_in_filt` is 1, and the configuration is zero (delay code 0, filter off).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration write byte address |
| cfg_wdata | input | DATA_W | Configuration write data |
| drv_req | input | 1 | Shifter SDA drive request (1 = pull low) |
| scl_in | input | 1 | Current SCL level |
| sda_pin | input | 1 | Raw SDA pad level |
| sda_oe | output | 1 | Delayed SDA output-enable to the pad (1 = pull low) |
| sda_in_filt | output | 1 | Synchronised, optionally filtered SDA input |

## Verification
The delay path is exercised with codes 0, 1, 2 and 3, with the drive change made at the same moment as the SCL fall. Sampling one cycle before and one cycle after the expected edge separates a correct step count from an off-by-one or a wrong step multiplier. A request raised during a long SCL-high phase shows whether the stage waits for the fall, and a second fall in mid-count shows whether the counter restarts. On the input side, the same level steps and pulses of two and three cycles are applied with the filter off and on; this separates the plain two-flop path from the three-sample qualifier and its exact rejection threshold.

// File: rtl/sdacond_pkg.sv
package sdacond_pkg;

    localparam int CODE_W = 2;
    localparam int LC_W   = CODE_W + 1;

    // Line-control register layout: bit 2 filter enable, bits 1:0 delay code.
    typedef struct packed {
        logic              filt_en;
        logic [CODE_W-1:0] code;
    } lc_cfg_t;

endpackage

// File: rtl/sdacond_lc_reg.sv
module sdacond_lc_reg
    import sdacond_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] LC_OFFSET = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output lc_cfg_t           cfg
);

    typedef struct packed {
        lc_cfg_t cfg;
    } state_t;

    state_t state_d, state_q;

    // Upper data bits carry no meaning for this register.
    logic unused_hi;
    assign unused_hi = ^cfg_wdata[DATA_W-1:LC_W];

    always_comb begin
        state_d = state_q;
        if (cfg_wr && (cfg_addr == LC_OFFSET)) begin
            state_d.cfg = lc_cfg_t'(cfg_wdata[LC_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cfg = state_q.cfg;

endmodule

// File: rtl/sdacond_hold_delay.sv
module sdacond_hold_delay
    import sdacond_pkg::*;
#(
    parameter int STEP = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              drv_req,
    input  logic              scl_in,
    output logic              sda_oe
);

    localparam int MAX_T = STEP * ((1 << CODE_W) - 1);
    localparam int CNT_W = $clog2(MAX_T + 1);

    typedef struct packed {
        logic             scl;
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic             oe;
    } state_t;

    state_t           state_d, state_q;
    logic             scl_fall;
    logic [CNT_W-1:0] target;

    always_comb begin
        state_d     = state_q;
        state_d.scl = scl_in;
        scl_fall    = state_q.scl & ~scl_in;
        target      = CNT_W'(int'(code) * STEP);

        if (code == '0) begin
            // No added hold time: one register stage.
            state_d.oe    = drv_req;
            state_d.armed = 1'b0;
            state_d.cnt   = '0;
        end else if (scl_fall) begin
            // Each falling clock restarts the hold window.
            state_d.armed = 1'b1;
            state_d.cnt   = CNT_W'(1);
        end else if (state_q.armed) begin
            if (state_q.cnt >= target) begin
                state_d.oe    = drv_req;
                state_d.armed = 1'b0;
            end else begin
                state_d.cnt = state_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{scl: 1'b1, armed: 1'b0, cnt: '0, oe: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign sda_oe = state_q.oe;

endmodule

// File: rtl/sdacond_in_filter.sv
module sdacond_in_filter #(
    parameter int SYNC_N   = 2,
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic filt_en,
    input  logic sda_pin,
    output logic sda_in_filt
);

    typedef struct packed {
        logic [SYNC_N-1:0]   sync;
        logic [FILT_LEN-2:0] hist;
        logic                filt;
    } state_t;

    state_t              state_d, state_q;
    logic                sync_out;
    logic [FILT_LEN-1:0] window;

    generate
        if (SYNC_N == 1) begin : g_sync1
            always_comb sync_out = state_q.sync[0];
        end else begin : g_syncn
            always_comb sync_out = state_q.sync[SYNC_N-1];
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        window  = {state_q.hist, sync_out};

        if (SYNC_N == 1) begin
            state_d.sync = sda_pin;
        end else begin
            state_d.sync = {state_q.sync[SYNC_N-2:0], sda_pin};
        end
        state_d.hist = window[FILT_LEN-2:0];

        if (!filt_en) begin
            state_d.filt = sync_out;
        end else if (&window) begin
            state_d.filt = 1'b1;
        end else if (~|window) begin
            state_d.filt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{sync: '1, hist: '1, filt: 1'b1};
        end else begin
            state_q <= state_d;
        end
    end

    assign sda_in_filt = filt_en ? state_q.filt : sync_out;

endmodule

// File: rtl/sda_line_cond.sv
module sda_line_cond
    import sdacond_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] LC_OFFSET = 'h10,
    parameter int                STEP      = 5,
    parameter int                SYNC_N    = 2,
    parameter int                FILT_LEN  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              drv_req,
    input  logic              scl_in,
    input  logic              sda_pin,
    output logic              sda_oe,
    output logic              sda_in_filt
);

    lc_cfg_t lc_cfg;

    sdacond_lc_reg #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .LC_OFFSET(LC_OFFSET)
    ) u_lc_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg      (lc_cfg)
    );

    sdacond_hold_delay #(
        .STEP(STEP)
    ) u_hold_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .code   (lc_cfg.code),
        .drv_req(drv_req),
        .scl_in (scl_in),
        .sda_oe (sda_oe)
    );

    sdacond_in_filter #(
        .SYNC_N  (SYNC_N),
        .FILT_LEN(FILT_LEN)
    ) u_in_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .filt_en    (lc_cfg.filt_en),
        .sda_pin    (sda_pin),
        .sda_in_filt(sda_in_filt)
    );

endmodule

// File: rtl/sda_line_cond_chk.sv
module sda_line_cond_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] LC_OFFSET = 'h10,
    parameter int                STEP      = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              drv_req,
    input logic              scl_in,
    input logic              sda_pin,
    input logic              sda_oe,
    input logic              sda_in_filt,
    input logic [1:0]        cfg_code,
    input logic              cfg_filt_en
);

    logic [3:0] cyc_q;
    logic [5:0] since_q;
    logic       scl_prev_q;
    logic [3:0] en_cnt_q;
    logic [3:0] dis_cnt_q;
    logic       fall_now;

    assign fall_now = scl_prev_q & ~scl_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q      <= '0;
            since_q    <= '0;
            scl_prev_q <= 1'b1;
            en_cnt_q   <= '0;
            dis_cnt_q  <= '0;
        end else begin
            scl_prev_q <= scl_in;
            if (cyc_q != 4'hF) cyc_q <= cyc_q + 4'd1;
            if (fall_now) since_q <= 6'd1;
            else if (since_q != 6'h3F) since_q <= since_q + 6'd1;
            if (!cfg_filt_en) en_cnt_q <= '0;
            else if (en_cnt_q != 4'hF) en_cnt_q <= en_cnt_q + 4'd1;
            if (cfg_filt_en) dis_cnt_q <= '0;
            else if (dis_cnt_q != 4'hF) dis_cnt_q <= dis_cnt_q + 4'd1;
        end
    end

    // R1: configuration only moves after a write to the line-control offset
    assert_cfg_write_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 4'd1 && !($past(cfg_wr) && $past(cfg_addr) == LC_OFFSET))
        |-> ($stable(cfg_code) && $stable(cfg_filt_en)));

    // R2: code zero is a single register stage
    assert_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 4'd2 && $past(cfg_code) == 2'd0) |-> (sda_oe == $past(drv_req)));

    // R3: no output change before the programmed hold window has elapsed
    assert_no_early_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 4'd2 && $past(cfg_code) != 2'd0 && sda_oe != $past(sda_oe))
        |-> (int'($past(since_q)) >= STEP * int'($past(cfg_code))));

    // R6: a fall in the apply cycle restarts the count instead of applying
    assert_restart_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 4'd2 && $past(cfg_code) != 2'd0 && sda_oe != $past(sda_oe))
        |-> !$past(fall_now));

    // R7: filter off gives the two-flop copy of the pin
    assert_sync_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 4'd3 && dis_cnt_q >= 4'd3) |-> (sda_in_filt == $past(sda_pin, 2)));

    // R8: filtered level only moves after three equal pin samples
    assert_filter_qualify_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 4'd8 && en_cnt_q >= 4'd6 && sda_in_filt != $past(sda_in_filt))
        |-> ($past(sda_pin, 3) == sda_in_filt && $past(sda_pin, 4) == sda_in_filt
             && $past(sda_pin, 5) == sda_in_filt));

endmodule

bind sda_line_cond sda_line_cond_chk #(
    .ADDR_W   (ADDR_W),
    .LC_OFFSET(LC_OFFSET),
    .STEP     (STEP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .drv_req    (drv_req),
    .scl_in     (scl_in),
    .sda_pin    (sda_pin),
    .sda_oe     (sda_oe),
    .sda_in_filt(sda_in_filt),
    .cfg_code   (lc_cfg.code),
    .cfg_filt_en(lc_cfg.filt_en)
);

// File: tb/sda_line_cond_bench.sv
`timescale 1ns/1ps
module sda_line_cond_bench;

    localparam time CLK_PER = 20ns;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_wr;
    logic [7:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic       drv_req;
    logic       scl_in;
    logic       sda_pin;
    logic       sda_oe;
    logic       sda_in_filt;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic exp_oe;

    always #(CLK_PER/2) clk = ~clk;

    sda_line_cond u_sda_line_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .drv_req    (drv_req),
        .scl_in     (scl_in),
        .sda_pin    (sda_pin),
        .sda_oe     (sda_oe),
        .sda_in_filt(sda_in_filt)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [7:0] addr, input logic [7:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = addr; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 oe after reset", sda_oe, 1'b0);
        check("R9 filt after reset", sda_in_filt, 1'b1);
        exp_oe = 1'b0;
    endtask

    task automatic t_passthrough();
        // default config after reset must be code 0 (R9, R2)
        scl_in = 1'b1;
        drv_req = 1'b1; tick(1);
        check("R2 pass rise (R9 code 0)", sda_oe, 1'b1);
        drv_req = 1'b0; tick(1);
        check("R2 pass fall", sda_oe, 1'b0);
        drv_req = 1'b1; tick(1);
        check("R2 pass rise again", sda_oe, 1'b1);
        exp_oe = 1'b1;
    endtask

    task automatic t_delay(input logic [1:0] code, input string tag);
        int   t;
        logic nv;
        t  = 5 * int'(code);
        nv = ~exp_oe;
        wr_cfg(8'h10, {6'b0, code});
        scl_in = 1'b1; tick(2);
        scl_in = 1'b0; drv_req = nv;
        tick(t);
        check({tag, " before window"}, sda_oe, ~nv);
        tick(1);
        check({tag, " at window"}, sda_oe, nv);
        exp_oe = nv;
        tick(2);
        scl_in = 1'b1; tick(1);
    endtask

    task automatic t_hold();
        logic nv;
        nv = ~exp_oe;
        wr_cfg(8'h10, 8'h01);
        scl_in = 1'b1; tick(1);
        drv_req = nv; tick(10);
        check("R5 held while scl high", sda_oe, ~nv);
        scl_in = 1'b0; tick(5);
        check("R5 before window", sda_oe, ~nv);
        tick(1);
        check("R5 applied after fall", sda_oe, nv);
        exp_oe = nv;
        tick(2); scl_in = 1'b1; tick(1);
    endtask

    task automatic t_restart();
        logic nv;
        nv = ~exp_oe;
        wr_cfg(8'h10, 8'h02);
        scl_in = 1'b1; tick(2);
        scl_in = 1'b0; drv_req = nv; tick(4);
        scl_in = 1'b1; tick(1);
        scl_in = 1'b0; tick(6);
        check("R6 no apply at first window", sda_oe, ~nv);
        tick(4);
        check("R6 before restarted window", sda_oe, ~nv);
        tick(1);
        check("R6 applied after restart", sda_oe, nv);
        exp_oe = nv;
        tick(2); scl_in = 1'b1; tick(1);
    endtask

    task automatic t_cfg_decode();
        logic nv;
        wr_cfg(8'h10, 8'h00);
        wr_cfg(8'h14, 8'h03);
        nv = ~exp_oe;
        scl_in = 1'b1; drv_req = nv; tick(1);
        check("R1 other address ignored", sda_oe, nv);
        exp_oe = nv;
        wr_cfg(8'h10, 8'hF9);   // code 1, filter off; upper bits ignored
        nv = ~exp_oe;
        scl_in = 1'b1; tick(2);
        scl_in = 1'b0; drv_req = nv; tick(5);
        check("R1 upper bits ignored, code 1 before", sda_oe, ~nv);
        tick(1);
        check("R1 code 1 at window", sda_oe, nv);
        exp_oe = nv;
        sda_pin = 1'b0; tick(1);
        check("R1 filter stays off", sda_in_filt, 1'b1);
        tick(1);
        check("R1 filter stays off copy", sda_in_filt, 1'b0);
        sda_pin = 1'b1; tick(3);
        scl_in = 1'b1;
        wr_cfg(8'h10, 8'h00);
        drv_req = exp_oe; tick(2);
    endtask

    task automatic t_filter_off();
        sda_pin = 1'b1; tick(4);
        sda_pin = 1'b0; tick(1);
        check("R7 one edge old", sda_in_filt, 1'b1);
        tick(1);
        check("R7 two edges new", sda_in_filt, 1'b0);
        sda_pin = 1'b1; tick(1);
        sda_pin = 1'b0; tick(1);
        check("R7 one-cycle pulse passes", sda_in_filt, 1'b1);
        sda_pin = 1'b1; tick(1);
        check("R7 one-cycle pulse low", sda_in_filt, 1'b0);
        tick(3);
    endtask

    task automatic t_filter_on();
        bit seen_low;
        wr_cfg(8'h10, 8'h04);
        sda_pin = 1'b1; tick(6);
        check("R8 idle high", sda_in_filt, 1'b1);
        sda_pin = 1'b0; tick(4);
        check("R8 step before qualify", sda_in_filt, 1'b1);
        tick(1);
        check("R8 step qualified", sda_in_filt, 1'b0);
        sda_pin = 1'b1; tick(8);
        check("R8 back high", sda_in_filt, 1'b1);
        seen_low = 1'b0;
        sda_pin = 1'b0; tick(2);
        sda_pin = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(1);
            if (sda_in_filt !== 1'b1) seen_low = 1'b1;
        end
        check("R8 two-cycle pulse suppressed", seen_low, 1'b0);
        sda_pin = 1'b0; tick(3);
        sda_pin = 1'b1; tick(2);
        check("R8 three-cycle pulse passes", sda_in_filt, 1'b0);
        tick(8);
        check("R8 recovers high", sda_in_filt, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        drv_req = 1'b0; scl_in = 1'b1; sda_pin = 1'b1;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_passthrough();
        t_delay(2'd1, "R3 code 1");
        t_delay(2'd2, "R3 code 2");
        t_delay(2'd3, "R4 code 3 fifteen");
        t_hold();
        t_restart();
        t_cfg_decode();
        t_filter_off();
        t_filter_on();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PER * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule